// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block collects a cache-line refill that comes back from the memory bus after a load misses in the data cache. The bus returns the line as four 64-bit double-word beats in wrapped order. The first beat is the double word the load asked for. Each beat is written into its own slot of a 256-bit line register.

The first beat is also passed combinationally to the waiting load unit, in the same cycle that it is written into the line register. The load therefore does not wait for the rest of the line. One cycle after the fourth beat is taken, the block raises a one-cycle done flag. The complete line is then ready for the cache write.

A fill opens with a start pulse that carries the requested address. Address bits [4:3] select the slot of the first beat. Beat strobes that arrive while no fill is open are dropped. A start pulse that arrives while a fill is open is also dropped.

Top module: `cwf_line_fill`

## Requirements
- R1: While reset is held and after it is released, `fwd_vld_o` and `line_done_o` are 0 and `line_o` is all zeros. The reset is synchronous and active-low.
- R2: The accepted start pulse sets the first slot to `req_addr_i[4:3]`. Beat k of the fill is written into slot (first + k) mod 4. Slot s occupies `line_o[64*s+63 : 64*s]`.
- R3: In the cycle the first beat of a fill is presented, `fwd_vld_o` is 1 and `fwd_data_o` equals `beat_data_i`. No register sits between the beat input and these outputs.
- R4: `fwd_vld_o` is high for exactly one cycle per fill, on the first beat only. `fwd_data_o` is zero whenever `fwd_vld_o` is 0.
- R5: `line_done_o` is high for exactly one cycle, in the cycle after the fourth beat is taken. In that cycle `line_o` holds all four beats at their slots.
- R6: A beat strobe while no fill is open changes nothing. `line_o` stays the same, and neither `fwd_vld_o` nor `line_done_o` rises.
- R7: A start pulse during an open fill is ignored. The slot order of that fill stays the same, and no second fill begins after its `line_done_o`.
- R8: Beats need not come in consecutive cycles. Idle cycles between beats neither advance the slot nor raise `fwd_vld_o`.
- R9: A start pulse is accepted when no fill is open, which includes the cycle in which `line_done_o` is high. The new fill's beats may begin in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens a fill when no fill is open |
| req_addr_i | input | 32 | Requested byte address; bits [4:3] select the first slot |
| beat_vld_i | input | 1 | Beat strobe |
| beat_data_i | input | 64 | Beat data |
| fwd_vld_o | output | 1 | Forwarded double word valid |
| fwd_data_o | output | 64 | Forwarded double word |
| line_done_o | output | 1 | One-cycle pulse when the line is complete |
| line_o | output | 256 | Assembled line |

## Verification
The checker watches several rules on every cycle:
- The forward pulse occurs only together with a beat and carries that beat's data.
- The forward pulse occurs only on the first beat of a fill.
- The done pulse lasts one cycle and comes only after four accepted beats.
- A beat strobe while idle leaves the line unchanged.
- A start pulse during a fill leaves the latched first slot unchanged.

Only the bench scenarios can show the following:
- Each beat lands in the correct slot for every starting offset.
- A fill can be chained into the done cycle.
- No new fill starts after a start pulse was rejected.

// File: rtl/cwf_pkg.sv
// Package: shared constants and helpers for the line fill buffer.
// Assumes beats are a power-of-two count of double words.
package cwf_pkg;
    localparam int unsigned BEAT_W_DEF = 64;
    localparam int unsigned BEATS_DEF  = 4;
    localparam int unsigned ADDR_W_DEF = 32;

    // One-hot decode of a slot index (width given by caller via cast).
    function automatic logic [31:0] slot_decode(input int unsigned idx);
        logic [31:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/cwf_fill_ctrl.sv
// Module: fill sequencer. Opens a fill on an accepted start, counts the
// accepted beats, walks the slot index modulo BEATS and raises the done
// pulse one cycle after the last beat. Assumes BEATS is a power of two.
module cwf_fill_ctrl #(
    parameter int unsigned BEATS  = 4,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFS_LO = 3,
    localparam int unsigned IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic             beat_vld_i,
    output logic             busy_o,
    output logic             beat_take_o,
    output logic             first_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [IDX_W-1:0] base_idx_o,
    output logic             done_o
);
    logic             busy_q;
    logic             done_q;
    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] base_q;
    logic             start_take;
    logic             last_beat;

    // Accept qualifiers for start and beat.
    always_comb begin
        start_take  = start_i && !busy_q;
        beat_take_o = busy_q && beat_vld_i;
        last_beat   = (cnt_q == IDX_W'(BEATS - 1));
    end

    // Sequencer state: busy flag, beat count, slot pointer, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            base_q <= '0;
        end else begin
            done_q <= beat_take_o && last_beat;
            if (start_take) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                idx_q  <= req_addr_i[OFS_LO +: IDX_W];
                base_q <= req_addr_i[OFS_LO +: IDX_W];
            end else if (beat_take_o) begin
                idx_q <= idx_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
                if (last_beat) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy_o     = busy_q;
    assign first_o    = (cnt_q == '0);
    assign wr_idx_o   = idx_q;
    assign base_idx_o = base_q;
    assign done_o     = done_q;
endmodule

// File: rtl/cwf_line_store.sv
// Module: line register split into BEATS slots of BEAT_W bits. A slot is
// written when the write strobe is high and the index selects it.
// Assumes at most one slot is written per cycle.
module cwf_line_store #(
    parameter int unsigned BEAT_W = 64,
    parameter int unsigned BEATS  = 4,
    localparam int unsigned IDX_W  = $clog2(BEATS),
    localparam int unsigned LINE_W = BEAT_W * BEATS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [BEAT_W-1:0] wr_data_i,
    output logic [LINE_W-1:0] line_o
);
    logic [BEATS-1:0] slot_sel;

    // Decode the write index into per-slot enables.
    always_comb begin
        slot_sel = wr_en_i ? BEATS'(cwf_pkg::slot_decode(int'(wr_idx_i))) : '0;
    end

    for (genvar s = 0; s < BEATS; s++) begin : g_slot
        logic [BEAT_W-1:0] slot_q;
        // Hold one double word of the line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (slot_sel[s]) begin
                slot_q <= wr_data_i;
            end
        end
        assign line_o[s*BEAT_W +: BEAT_W] = slot_q;
    end
endmodule

// File: rtl/cwf_fwd_path.sv
// Module: combinational bypass of the critical double word to the load
// unit. Assumes the accept and first-beat qualifiers come from the
// sequencer in the same cycle as the beat.
module cwf_fwd_path #(
    parameter int unsigned BEAT_W = 64
) (
    input  logic              beat_take_i,
    input  logic              first_i,
    input  logic [BEAT_W-1:0] beat_data_i,
    output logic              fwd_vld_o,
    output logic [BEAT_W-1:0] fwd_data_o
);
    // Pass the first beat through, zero otherwise.
    always_comb begin
        fwd_vld_o  = beat_take_i && first_i;
        fwd_data_o = fwd_vld_o ? beat_data_i : '0;
    end
endmodule

// File: rtl/cwf_line_fill.sv
// Module: top of the critical-word-first line fill buffer. Ties the
// sequencer, line register and forward bypass together.
// Assumes the bus returns beats in wrapped order from the requested slot.
module cwf_line_fill #(
    parameter int unsigned BEAT_W = cwf_pkg::BEAT_W_DEF,
    parameter int unsigned BEATS  = cwf_pkg::BEATS_DEF,
    parameter int unsigned ADDR_W = cwf_pkg::ADDR_W_DEF,
    localparam int unsigned IDX_W  = $clog2(BEATS),
    localparam int unsigned LINE_W = BEAT_W * BEATS,
    localparam int unsigned OFS_LO = $clog2(BEAT_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              beat_vld_i,
    input  logic [BEAT_W-1:0] beat_data_i,
    output logic              fwd_vld_o,
    output logic [BEAT_W-1:0] fwd_data_o,
    output logic              line_done_o,
    output logic [LINE_W-1:0] line_o
);
    logic             busy;
    logic             beat_take;
    logic             first;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] base_idx;

    cwf_fill_ctrl #(.BEATS(BEATS), .ADDR_W(ADDR_W), .OFS_LO(OFS_LO)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .req_addr_i (req_addr_i),
        .beat_vld_i (beat_vld_i),
        .busy_o     (busy),
        .beat_take_o(beat_take),
        .first_o    (first),
        .wr_idx_o   (wr_idx),
        .base_idx_o (base_idx),
        .done_o     (line_done_o)
    );

    cwf_line_store #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (beat_take),
        .wr_idx_i (wr_idx),
        .wr_data_i(beat_data_i),
        .line_o   (line_o)
    );

    cwf_fwd_path #(.BEAT_W(BEAT_W)) u_fwd (
        .beat_take_i(beat_take),
        .first_i    (first),
        .beat_data_i(beat_data_i),
        .fwd_vld_o  (fwd_vld_o),
        .fwd_data_o (fwd_data_o)
    );
endmodule

// File: rtl/cwf_line_fill_chk.sv
// Module: protocol checker for cwf_line_fill, attached by bind. Keeps its
// own count of accepted beats per fill.
module cwf_line_fill_chk #(
    parameter int unsigned BEAT_W = 64,
    parameter int unsigned BEATS  = 4,
    localparam int unsigned IDX_W  = $clog2(BEATS),
    localparam int unsigned LINE_W = BEAT_W * BEATS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              beat_vld_i,
    input logic [BEAT_W-1:0] beat_data_i,
    input logic              fwd_vld_o,
    input logic [BEAT_W-1:0] fwd_data_o,
    input logic              line_done_o,
    input logic [LINE_W-1:0] line_o,
    input logic              busy,
    input logic              beat_take,
    input logic [IDX_W-1:0]  base_idx
);
    logic [IDX_W:0] seen_q;

    // Count accepted beats of the current fill; clear on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (line_done_o) begin
            seen_q <= beat_take ? 1 : '0;
        end else if (beat_take) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    p_fwd_with_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld_o |-> (beat_vld_i && fwd_data_o == beat_data_i));

    p_fwd_first_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld_o |-> (seen_q == '0));

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |=> !line_done_o);

    p_done_after_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> (seen_q == (IDX_W+1)'(BEATS)));

    p_idle_beat_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && beat_vld_i) |=> $stable(line_o));

    p_start_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> $stable(base_idx));
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .beat_vld_i (beat_vld_i),
    .beat_data_i(beat_data_i),
    .fwd_vld_o  (fwd_vld_o),
    .fwd_data_o (fwd_data_o),
    .line_done_o(line_done_o),
    .line_o     (line_o),
    .busy       (busy),
    .beat_take  (beat_take),
    .base_idx   (base_idx)
);

// File: tb/test_cwf_line_fill.sv
module test_cwf_line_fill;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  req_addr_i = '0;
    logic         beat_vld_i = 1'b0;
    logic [63:0]  beat_data_i = '0;
    logic         fwd_vld_o;
    logic [63:0]  fwd_data_o;
    logic         line_done_o;
    logic [255:0] line_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [255:0] exp_line;

    // Vectors: {seed[31:0], addr[7:0], gaps, inject_start}
    localparam logic [41:0] VEC [6] = '{
        {32'h1111_0001, 8'h00, 1'b0, 1'b0},
        {32'h2222_0002, 8'h28, 1'b0, 1'b0},
        {32'h3333_0003, 8'hF7, 1'b0, 1'b0},
        {32'h4444_0004, 8'h18, 1'b0, 1'b0},
        {32'h5555_0005, 8'h08, 1'b1, 1'b0},
        {32'h6666_0006, 8'h10, 1'b0, 1'b1}
    };

    cwf_line_fill i_cwf_line_fill (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_addr_i(req_addr_i),
        .beat_vld_i(beat_vld_i), .beat_data_i(beat_data_i),
        .fwd_vld_o(fwd_vld_o), .fwd_data_o(fwd_data_o),
        .line_done_o(line_done_o), .line_o(line_o)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] beat_val(input logic [31:0] seed, input int k);
        return {seed, 24'h5A5A5A, 8'(k)};
    endfunction

    task automatic check(input logic ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One fill; ends at the negedge of the done cycle.
    task automatic run_fill(input logic [31:0] addr, input logic [31:0] seed,
                            input logic gaps, input logic inject, input logic now);
        int first = int'(addr[4:3]);
        exp_line = line_o;
        if (!now) @(negedge clk);
        start_i = 1'b1;
        req_addr_i = addr;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (gaps && k > 0) begin
                #1 check(!fwd_vld_o, "R8 gap no fwd", 256'(fwd_vld_o), 256'(0));
                @(negedge clk);
            end
            beat_vld_i = 1'b1;
            beat_data_i = beat_val(seed, k);
            if (inject && k == 2) begin
                start_i = 1'b1;
                req_addr_i = addr ^ 32'h18;
            end
            exp_line[((first + k) % 4)*64 +: 64] = beat_val(seed, k);
            #1;
            check(fwd_vld_o == (k == 0), "R3/R4 fwd_vld", 256'(fwd_vld_o), 256'(k == 0));
            check(fwd_data_o == ((k == 0) ? beat_data_i : 64'h0), "R3/R4 fwd_data",
                  256'(fwd_data_o), 256'((k == 0) ? beat_data_i : 64'h0));
            check(!line_done_o, "R5 no early done", 256'(line_done_o), 256'(0));
            @(negedge clk);
            beat_vld_i = 1'b0;
            start_i = 1'b0;
        end
        #1;
        check(line_done_o, "R5 done", 256'(line_done_o), 256'(1));
        check(line_o == exp_line, "R2/R5 line order", line_o, exp_line);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [255:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!fwd_vld_o && !line_done_o && line_o == '0, "R1 in reset",
              line_o, 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(!fwd_vld_o && !line_done_o && line_o == '0, "R1 after reset",
                 line_o, 256'(0));

        // Vector table walk: R2, R3, R4, R5, R7, R8
        for (int v = 0; v < 6; v++) begin
            run_fill({24'h0, VEC[v][9:2]}, VEC[v][41:10], VEC[v][1], VEC[v][0], 1'b0);
            @(negedge clk);
            #1 check(!line_done_o, "R5 done one cycle", 256'(line_done_o), 256'(0));
            if (VEC[v][0]) begin
                // R7: no fill may have opened from the rejected start
                held = line_o;
                beat_vld_i = 1'b1;
                beat_data_i = 64'hDEAD_BEEF_0000_0007;
                #1 check(!fwd_vld_o, "R7 rejected start no fwd", 256'(fwd_vld_o), 256'(0));
                @(negedge clk);
                beat_vld_i = 1'b0;
                #1 check(line_o == held, "R7 rejected start no write", line_o, held);
            end
        end

        // R6: beats while idle
        held = line_o;
        beat_vld_i = 1'b1;
        beat_data_i = 64'hFFFF_0000_FFFF_0000;
        #1 check(!fwd_vld_o, "R6 idle no fwd", 256'(fwd_vld_o), 256'(0));
        @(negedge clk);
        #1 check(!fwd_vld_o, "R6 idle no fwd 2", 256'(fwd_vld_o), 256'(0));
        @(negedge clk);
        beat_vld_i = 1'b0;
        #1;
        check(line_o == held, "R6 idle line unchanged", line_o, held);
        check(!line_done_o, "R6 idle no done", 256'(line_done_o), 256'(0));

        // R9: chain a new fill from the done cycle
        run_fill(32'h0000_0030, 32'h7777_0007, 1'b0, 1'b0, 1'b0);
        run_fill(32'h0000_0008, 32'h8888_0008, 1'b0, 1'b0, 1'b1);
        check(line_o == exp_line, "R9 chained fill", line_o, exp_line);
        @(negedge clk);

        // R1: reset mid-fill returns to the zero state
        start_i = 1'b1;
        req_addr_i = 32'h10;
        @(negedge clk);
        start_i = 1'b0;
        beat_vld_i = 1'b1;
        beat_data_i = 64'h1234;
        @(negedge clk);
        beat_vld_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(line_o == '0 && !line_done_o, "R1 reset mid fill", line_o, 256'(0));
        beat_vld_i = 1'b1;
        #1 check(!fwd_vld_o, "R1 no fill after reset", 256'(fwd_vld_o), 256'(0));
        @(negedge clk);
        beat_vld_i = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule